// File: doc/BRIEF.md
# Hadron Candidate Sorter with Energy Sum

The block takes eight calorimeter cluster words in every bunch crossing, one per input channel, and reduces them to the two most energetic distinct clusters plus the total transverse energy of all distinct clusters. Each 21-bit word carries a crossing number in its upper byte, a transverse energy in its middle byte and a 5-bit channel-local position in its low bits. The block widens the local position to a full 8-bit cluster address by prefixing the 3-bit channel number.

The same physical cluster can appear on more than one channel. To spot such copies, every full address is translated through a 256-entry identity table. Two words whose translated identities match are copies, and only one of them survives. After this merge, a ranking stage picks the leader and the runner-up. The second output can therefore never repeat the first cluster. The translation table is loaded through a simple write port. After reset it maps every address to itself.

The block is a four-register pipeline and accepts a new set of words on every clock.

Top module: `hadron_sorter`

## Requirements
- R1: The address reported with each selected cluster is {channel number[2:0], local position[4:0]}. The channel number is i for word i, and word i sits at chan_i[21*i +: 21] with bits [20:13] holding the crossing number, [12:5] the energy and [4:0] the local position.
- R2: A word with zero energy is no candidate. It adds nothing to the sum. When fewer than one or two candidates remain, the matching valid output is 0 and its energy and address read 0.
- R3: Words whose full addresses map to the same table identity are one cluster. Only the copy with the highest energy is kept, and on equal energy the copy on the lower channel is kept.
- R4: The first output is the kept cluster with the highest energy. On equal energy the lower channel wins.
- R5: The second output is the best kept cluster after the first. It is never the same cluster as the first, and second_vld is 1 only when first_vld is 1.
- R6: esum is the 11-bit sum of the energies of all kept clusters, with each cluster counted once.
- R7: bx_o repeats channel 0's crossing number. bx_err is 1 when any channel's crossing number differs from channel 0's.
- R8: Every output belongs to the set of words sampled four rising edges earlier. A new set is accepted on every edge.
- R9: While rst_n is low at a rising edge, all outputs become 0 and table entry k is set to k.
- R10: With map_we high at a rising edge, table entry map_idx takes map_val. Words sampled at that same edge still use the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_i | input | 168 | Eight packed 21-bit cluster words |
| map_we | input | 1 | Table write strobe |
| map_idx | input | 8 | Full address whose table entry is written |
| map_val | input | 8 | Identity written to the table |
| first_vld | output | 1 | Leader present |
| first_e | output | 8 | Leader energy |
| first_addr | output | 8 | Leader full address |
| second_vld | output | 1 | Runner-up present |
| second_e | output | 8 | Runner-up energy |
| second_addr | output | 8 | Runner-up full address |
| esum | output | 11 | Energy sum of kept clusters |
| bx_o | output | 8 | Crossing number of channel 0 |
| bx_err | output | 1 | Crossing numbers disagree |

## Verification
All outputs for the word set driven before rising edge n (the leader, the runner-up, the sum and the crossing flags) are due just after edge n+3. The bench drives on falling edges and keeps a four-deep history of expected results. On each falling edge it compares the outputs with the entry that has just aged out of that history, before it pushes the next expectation. An off-by-one latency is therefore caught on every vector. Table writes enter the bench's model only after the expectation for the same edge has been computed, as R10 requires.

// File: rtl/hs_pkg.sv
// Shared sizes and types for the hadron candidate sorter.
// Assumes a power-of-two channel count.
package hs_pkg;
    localparam int NCH   = 8;                 // input channels
    localparam int BXW   = 8;                 // crossing number width
    localparam int EW    = 8;                 // energy width
    localparam int AW    = 5;                 // local position width
    localparam int CHW   = $clog2(NCH);       // channel number width
    localparam int FAW   = CHW + AW;          // full address width
    localparam int IDW   = FAW;               // table identity width
    localparam int WW    = BXW + EW + AW;     // word width
    localparam int SUMW  = EW + CHW;          // sum width
    localparam int TBL_N = 1 << FAW;          // table depth

    typedef logic [EW-1:0]  energy_t;
    typedef logic [FAW-1:0] faddr_t;
    typedef logic [IDW-1:0] cid_t;
endpackage

// File: rtl/hs_lookup.sv
// Stage 1: splits the packed words, builds full addresses, translates them
// through the identity table and flags crossing-number disagreement.
// Assumes table writes and lookups share an edge; lookups see the old entry.
module hs_lookup
    import hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*WW-1:0] chan_i,
    input  logic              map_we,
    input  faddr_t            map_idx,
    input  cid_t              map_val,
    output energy_t           e_o   [NCH],
    output faddr_t            fa_o  [NCH],
    output cid_t              id_o  [NCH],
    output logic [BXW-1:0]    bx_o,
    output logic              bxerr_o
);
    cid_t           tbl [TBL_N];
    logic [BXW-1:0] bx_w [NCH];
    logic           bxerr_c;

    // Table storage: identity on reset, single write port otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TBL_N; k++) tbl[k] <= cid_t'(k);
        end else if (map_we) begin
            tbl[map_idx] <= map_val;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [AW-1:0] loc;
        faddr_t        full;
        assign bx_w[g] = chan_i[g*WW + AW + EW +: BXW];
        assign loc     = chan_i[g*WW +: AW];
        assign full    = {CHW'(g), loc};

        // Per-channel capture of energy, full address and identity.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_o[g]  <= '0;
                fa_o[g] <= '0;
                id_o[g] <= '0;
            end else begin
                e_o[g]  <= chan_i[g*WW + AW +: EW];
                fa_o[g] <= full;
                id_o[g] <= tbl[full];
            end
        end
    end

    // Crossing-number agreement against channel 0.
    always_comb begin
        bxerr_c = 1'b0;
        for (int i = 1; i < NCH; i++) bxerr_c |= (bx_w[i] != bx_w[0]);
    end

    // Register crossing number and disagreement flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bx_o    <= '0;
            bxerr_o <= 1'b0;
        end else begin
            bx_o    <= bx_w[0];
            bxerr_o <= bxerr_c;
        end
    end
endmodule

// File: rtl/hs_dedup.sv
// Stage 2: marks which words survive as distinct candidates. Zero energy
// drops a word; among words with equal identity the highest energy, then the
// lowest channel, survives.
module hs_dedup
    import hs_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  energy_t        e_i    [NCH],
    input  faddr_t         fa_i   [NCH],
    input  cid_t           id_i   [NCH],
    input  logic [BXW-1:0] bx_i,
    input  logic           bxerr_i,
    output energy_t        e_o    [NCH],
    output faddr_t         fa_o   [NCH],
    output logic [NCH-1:0] keep_o,
    output logic [BXW-1:0] bx_o,
    output logic           bxerr_o
);
    logic [NCH-1:0] keep_c;
    logic           dup_pair;

    // Survivor mask: a word loses to any live copy that outranks it.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            keep_c[i] = (e_i[i] != '0);
            for (int j = 0; j < NCH; j++) begin
                if (j != i && e_i[j] != '0 && id_i[j] == id_i[i] &&
                    (e_i[j] > e_i[i] || (e_i[j] == e_i[i] && j < i)))
                    keep_c[i] = 1'b0;
            end
        end
    end

    // Checker aid: two survivors sharing one identity.
    always_comb begin
        dup_pair = 1'b0;
        for (int i = 0; i < NCH; i++)
            for (int j = i + 1; j < NCH; j++)
                if (keep_c[i] && keep_c[j] && id_i[i] == id_i[j]) dup_pair = 1'b1;
    end

    // Pipeline register for stage 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                e_o[i]  <= '0;
                fa_o[i] <= '0;
            end
            keep_o  <= '0;
            bx_o    <= '0;
            bxerr_o <= 1'b0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                e_o[i]  <= e_i[i];
                fa_o[i] <= fa_i[i];
            end
            keep_o  <= keep_c;
            bx_o    <= bx_i;
            bxerr_o <= bxerr_i;
        end
    end

    // R3
    dedup_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup_pair);
endmodule

// File: rtl/hs_rank.sv
// Stage 3: ranks the surviving words and sums their energies. Rank is the
// count of survivors that beat a word (higher energy, or equal energy on a
// lower channel); rank 0 is the leader, rank 1 the runner-up.
module hs_rank
    import hs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  energy_t         e_i    [NCH],
    input  faddr_t          fa_i   [NCH],
    input  logic [NCH-1:0]  keep_i,
    input  logic [BXW-1:0]  bx_i,
    input  logic            bxerr_i,
    output energy_t         e_o    [NCH],
    output faddr_t          fa_o   [NCH],
    output logic [NCH-1:0]  top1_o,
    output logic [NCH-1:0]  top2_o,
    output logic [SUMW-1:0] sum_o,
    output logic [BXW-1:0]  bx_o,
    output logic            bxerr_o
);
    logic [CHW:0]    rank_c [NCH];
    logic [NCH-1:0]  top1_c, top2_c;
    logic [SUMW-1:0] sum_c;

    // Rank each survivor against all others.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            rank_c[i] = '0;
            for (int j = 0; j < NCH; j++) begin
                if (j != i && keep_i[j] &&
                    (e_i[j] > e_i[i] || (e_i[j] == e_i[i] && j < i)))
                    rank_c[i] = rank_c[i] + 1'b1;
            end
            top1_c[i] = keep_i[i] && (rank_c[i] == 0);
            top2_c[i] = keep_i[i] && (rank_c[i] == 1);
        end
    end

    // Energy total over survivors.
    always_comb begin
        sum_c = '0;
        for (int i = 0; i < NCH; i++)
            if (keep_i[i]) sum_c = sum_c + SUMW'(e_i[i]);
    end

    // Pipeline register for stage 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                e_o[i]  <= '0;
                fa_o[i] <= '0;
            end
            top1_o  <= '0;
            top2_o  <= '0;
            sum_o   <= '0;
            bx_o    <= '0;
            bxerr_o <= 1'b0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                e_o[i]  <= e_i[i];
                fa_o[i] <= fa_i[i];
            end
            top1_o  <= top1_c;
            top2_o  <= top2_c;
            sum_o   <= sum_c;
            bx_o    <= bx_i;
            bxerr_o <= bxerr_i;
        end
    end

    // R4
    one_leader_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(top1_o));
    // R5
    one_runner_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(top2_o));
    // R5
    leader_runner_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top1_o & top2_o) == '0);
    // R4
    leader_if_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|keep_i) |=> (|top1_o));
endmodule

// File: rtl/hadron_sorter.sv
// Top: four-register pipeline (lookup, merge, rank, output select) that
// reports the two most energetic distinct clusters and their energy sum.
// Assumes the caller loads the identity table between bursts if results
// must not mix old and new mappings.
module hadron_sorter
    import hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*WW-1:0] chan_i,
    input  logic              map_we,
    input  logic [FAW-1:0]    map_idx,
    input  logic [IDW-1:0]    map_val,
    output logic              first_vld,
    output logic [EW-1:0]     first_e,
    output logic [FAW-1:0]    first_addr,
    output logic              second_vld,
    output logic [EW-1:0]     second_e,
    output logic [FAW-1:0]    second_addr,
    output logic [SUMW-1:0]   esum,
    output logic [BXW-1:0]    bx_o,
    output logic              bx_err
);
    energy_t         s1_e [NCH], s2_e [NCH], s3_e [NCH];
    faddr_t          s1_fa[NCH], s2_fa[NCH], s3_fa[NCH];
    cid_t            s1_id[NCH];
    logic [BXW-1:0]  s1_bx, s2_bx, s3_bx;
    logic            s1_err, s2_err, s3_err;
    logic [NCH-1:0]  s2_keep, s3_top1, s3_top2;
    logic [SUMW-1:0] s3_sum;
    energy_t         pick1_e, pick2_e;
    faddr_t          pick1_a, pick2_a;

    hs_lookup u_lookup (
        .clk(clk), .rst_n(rst_n), .chan_i(chan_i),
        .map_we(map_we), .map_idx(map_idx), .map_val(map_val),
        .e_o(s1_e), .fa_o(s1_fa), .id_o(s1_id), .bx_o(s1_bx), .bxerr_o(s1_err)
    );

    hs_dedup u_dedup (
        .clk(clk), .rst_n(rst_n),
        .e_i(s1_e), .fa_i(s1_fa), .id_i(s1_id), .bx_i(s1_bx), .bxerr_i(s1_err),
        .e_o(s2_e), .fa_o(s2_fa), .keep_o(s2_keep), .bx_o(s2_bx), .bxerr_o(s2_err)
    );

    hs_rank u_rank (
        .clk(clk), .rst_n(rst_n),
        .e_i(s2_e), .fa_i(s2_fa), .keep_i(s2_keep), .bx_i(s2_bx), .bxerr_i(s2_err),
        .e_o(s3_e), .fa_o(s3_fa), .top1_o(s3_top1), .top2_o(s3_top2),
        .sum_o(s3_sum), .bx_o(s3_bx), .bxerr_o(s3_err)
    );

    // One-hot select of leader and runner-up fields.
    always_comb begin
        pick1_e = '0; pick1_a = '0;
        pick2_e = '0; pick2_a = '0;
        for (int i = 0; i < NCH; i++) begin
            if (s3_top1[i]) begin
                pick1_e |= s3_e[i];
                pick1_a |= s3_fa[i];
            end
            if (s3_top2[i]) begin
                pick2_e |= s3_e[i];
                pick2_a |= s3_fa[i];
            end
        end
    end

    // Output register (stage 4).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_vld   <= 1'b0;
            first_e     <= '0;
            first_addr  <= '0;
            second_vld  <= 1'b0;
            second_e    <= '0;
            second_addr <= '0;
            esum        <= '0;
            bx_o        <= '0;
            bx_err      <= 1'b0;
        end else begin
            first_vld   <= |s3_top1;
            first_e     <= pick1_e;
            first_addr  <= pick1_a;
            second_vld  <= |s3_top2;
            second_e    <= pick2_e;
            second_addr <= pick2_a;
            esum        <= s3_sum;
            bx_o        <= s3_bx;
            bx_err      <= s3_err;
        end
    end

    // R5
    runner_needs_leader_chk: assert property (@(posedge clk) disable iff (!rst_n)
        second_vld |-> first_vld);
    // R5
    runner_not_leader_chk: assert property (@(posedge clk) disable iff (!rst_n)
        second_vld |-> (second_addr != first_addr));
    // R4
    leader_not_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        second_vld |-> (first_e >= second_e));
    // R6
    sum_covers_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        esum >= (SUMW'(first_e) + SUMW'(second_e)));
    // R2
    empty_means_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !first_vld |-> (esum == '0 && first_e == '0));
endmodule

// File: tb/hadron_sorter_bench.sv
`timescale 1ns/1ps
module hadron_sorter_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [167:0] chan = '0;
    logic         map_we = 1'b0;
    logic [7:0]   map_idx = '0, map_val = '0;
    logic         first_vld, second_vld, bx_err;
    logic [7:0]   first_e, first_addr, second_e, second_addr, bx_o;
    logic [10:0]  esum;

    typedef struct packed {
        logic       live;
        logic       fv;  logic [7:0] fe; logic [7:0] fa;
        logic       sv;  logic [7:0] se; logic [7:0] sa;
        logic [10:0] sum; logic [7:0] bx; logic err;
    } exp_t;

    exp_t       hist [4];
    logic [7:0] mtbl [256];
    logic [7:0] ve [8];
    logic [4:0] va [8];
    logic [7:0] vb [8];
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    hadron_sorter u_hadron_sorter (
        .clk(clk), .rst_n(rst_n), .chan_i(chan),
        .map_we(map_we), .map_idx(map_idx), .map_val(map_val),
        .first_vld(first_vld), .first_e(first_e), .first_addr(first_addr),
        .second_vld(second_vld), .second_e(second_e), .second_addr(second_addr),
        .esum(esum), .bx_o(bx_o), .bx_err(bx_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference from the requirements: merge copies, then scan for the best two.
    function automatic exp_t model();
        exp_t r;
        logic keep [8];
        logic [7:0] id [8];
        int b1 = -1, b2 = -1;
        r = '0;
        r.live = 1'b1;
        for (int i = 0; i < 8; i++) begin
            keep[i] = (ve[i] != 0);
            id[i]   = mtbl[{i[2:0], va[i]}];
        end
        for (int i = 0; i < 8; i++)
            for (int j = i + 1; j < 8; j++)
                if (keep[i] && keep[j] && id[i] == id[j]) begin
                    if (ve[j] > ve[i]) keep[i] = 1'b0; else keep[j] = 1'b0;
                end
        for (int i = 0; i < 8; i++)
            if (keep[i]) begin
                r.sum = r.sum + 11'(ve[i]);
                if (b1 < 0 || ve[i] > ve[b1]) b1 = i;
            end
        for (int i = 0; i < 8; i++)
            if (keep[i] && i != b1 && (b2 < 0 || ve[i] > ve[b2])) b2 = i;
        if (b1 >= 0) begin r.fv = 1; r.fe = ve[b1]; r.fa = {b1[2:0], va[b1]}; end
        if (b2 >= 0) begin r.sv = 1; r.se = ve[b2]; r.sa = {b2[2:0], va[b2]}; end
        r.bx = vb[0];
        for (int i = 1; i < 8; i++) if (vb[i] != vb[0]) r.err = 1;
        return r;
    endfunction

    // One falling edge: check the result due now, then drive the next set.
    task automatic step(input logic we, input logic [7:0] widx, input logic [7:0] wval);
        exp_t e;
        @(negedge clk);
        e = hist[3];
        if (e.live) begin  // R8: due exactly four edges after sampling
            chk("R4 first_vld",   first_vld,   e.fv);
            chk("R4 first_e",     first_e,     e.fe);
            chk("R1 first_addr",  first_addr,  e.fa);
            chk("R5 second_vld",  second_vld,  e.sv);
            chk("R5 second_e",    second_e,    e.se);
            chk("R1 second_addr", second_addr, e.sa);
            chk("R6 esum",        esum,        e.sum);
            chk("R7 bx_o",        bx_o,        e.bx);
            chk("R7 bx_err",      bx_err,      e.err);
        end
        for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = model();           // old table applies at the write edge (R10)
        for (int i = 0; i < 8; i++) chan[i*21 +: 21] = {vb[i], ve[i], va[i]};
        map_we = we; map_idx = widx; map_val = wval;
        if (we) mtbl[widx] = wval;
    endtask

    task automatic clear_set(input logic [7:0] bx);
        for (int i = 0; i < 8; i++) begin ve[i] = 0; va[i] = 0; vb[i] = bx; end
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) mtbl[k] = 8'(k);
        for (int k = 0; k < 4; k++) hist[k] = '0;
        clear_set(8'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs cleared by reset
        chk("R9 first_vld", first_vld, 0);
        chk("R9 esum", esum, 0);
        chk("R9 first_addr", first_addr, 0);
        rst_n = 1'b1;

        // R9: identity table keeps equal positions on channels 0 and 1 apart
        clear_set(8'd7);
        ve[0] = 40; va[0] = 3; ve[1] = 40; va[1] = 3;
        step(0, 0, 0);
        // R2: zero energies only, plus a single candidate
        clear_set(8'd8); step(0, 0, 0);
        clear_set(8'd9); ve[6] = 200; va[6] = 31; step(0, 0, 0);
        // R4: ties on energy resolved toward the lower channel
        clear_set(8'd10); ve[5] = 90; ve[2] = 90; ve[7] = 90; va[2] = 4; step(0, 0, 0);
        // R6: full-scale sum 8 x 255
        clear_set(8'd11);
        for (int i = 0; i < 8; i++) begin ve[i] = 255; va[i] = 5'(i); end
        step(0, 0, 0);
        // R7: crossing numbers disagree
        clear_set(8'd12); vb[4] = 8'd13; ve[3] = 20; step(0, 0, 0);

        // R10, R3: map {2,7} onto identity 3, then present both copies
        clear_set(8'd0);
        step(1, {3'd2, 5'd7}, 8'd3);
        clear_set(8'd1); ve[0] = 50; va[0] = 3; ve[2] = 80; va[2] = 7; step(0, 0, 0);
        // R3: equal-energy copies keep the lower channel
        clear_set(8'd2); ve[0] = 60; va[0] = 3; ve[2] = 60; va[2] = 7; ve[4] = 10; step(0, 0, 0);

        // Load copy groups: channel 1 mirrors channel 0, channel 5 mirrors 4
        clear_set(8'd0);
        for (int a = 0; a < 4; a++) begin
            step(1, {3'd1, 5'(a)}, {3'd0, 5'(a)});
            step(1, {3'd5, 5'(a)}, {3'd4, 5'(a)});
        end

        // Random sets with frequent copies, ties and zeros (R2, R3, R4, R5, R6)
        void'($urandom(32'd4711));
        for (int n = 0; n < 400; n++) begin
            logic [7:0] bx;
            bx = 8'($urandom);
            for (int i = 0; i < 8; i++) begin
                ve[i] = ($urandom % 4 == 0) ? 8'd0 : 8'($urandom);
                va[i] = 5'($urandom % 4);
                vb[i] = bx;
            end
            if ($urandom % 2 == 0) begin ve[1] = ve[0]; va[1] = va[0]; end
            if ($urandom % 3 == 0) begin ve[5] = ve[4]; va[5] = va[4]; end
            if ($urandom % 4 == 0) ve[7] = ve[3];
            if ($urandom % 10 == 0) vb[$urandom % 8] = 8'($urandom);
            step(0, 0, 0);
        end

        clear_set(8'd0);
        repeat (5) step(0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule